// File: doc/BRIEF.md
# Banked Multiprocessor Interrupt Pending Distributor

This block holds the pending state of a set of interrupt lines for up to eight processors. Interrupts 0 to 31 are private: every processor has its own bank of pending bits for them. Interrupts from 32 up to the configured count are shared. Each shared interrupt has one pending latch and a processor target mask, and the pending state a processor sees is the latch gated by that mask.

Software reaches the state through a byte-wide write port. Each write carries an address, a data byte, the number of the processor making the request and a non-secure attribute. Through this port software can set pending bits, clear pending bits, write group bits and write target masks. A separate combinational read port returns the state that the requesting processor sees. Hardware inputs for the shared interrupts also raise pending state. The block drives a pending vector for each processor and a summary bit for each processor.

Top module: `irq_pend_dist`

## Requirements
- R1: After a synchronous active-low reset, every pending, target and group bit is zero. Every output and every read returns zero, except target reads of private interrupts (see R6).
- R2: The write and read address is {region[1:0], index}, and index is $clog2(NUM_IRQ) bits wide. Region 0 is set-pending, 1 is clear-pending, 2 is group, 3 is target. In regions 0 to 2, data bit i of byte index b acts on interrupt 8*b+i, and a zero bit leaves that interrupt unchanged. In region 3 the index is the interrupt number. State changes at the rising clock edge that samples the write.
- R3: A set-pending write to a private interrupt makes it pending only in the bank of the processor numbered by wr_cpu. Other banks do not change. A wr_cpu of NUM_CPU or more changes no private bank.
- R4: A clear-pending write to a private interrupt clears pending only in the bank of the writing processor.
- R5: A set-pending write to a shared interrupt latches it pending, and it is seen by the processors in its current target mask. A clear-pending write to a shared interrupt removes it for every processor, whoever writes.
- R6: Target mask bits at or above NUM_CPU are stored as zero. A target read of a private interrupt returns the all-processor mask (NUM_CPU low ones), and target writes to private interrupts have no effect. With NUM_CPU equal to 1, every target read returns zero and target writes are ignored.
- R7: Rewriting the target mask of a pending shared interrupt moves its pending state in the same edge. Processors added to the mask see it pending and processors removed from it stop seeing it. A shared interrupt latched while its mask was empty becomes visible when a processor is added.
- R8: A high hw_irq bit j at a rising edge makes shared interrupt 32+j pending, the same as a set-pending write. If a clear-pending write to the same interrupt falls in the same cycle, the interrupt stays pending.
- R9: When SEC_EN is 1, a set-pending or clear-pending bit written with wr_nonsec=1 to an interrupt whose group bit is 0 is ignored. Group-1 interrupts and secure writes are applied.
- R10: A set, clear or group byte index at or above NUM_IRQ/8, or a target index at or above NUM_IRQ, changes no state and reads as zero.
- R11: cpu_pend_vec[c*NUM_IRQ+k] is interrupt k as seen by processor c. cpu_pend[c] is high when any of those bits is high. A read of region 0 or 1 returns byte index b of rd_cpu's view, and a read of region 2 returns the group byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address {region, index} |
| wr_data | input | 8 | Write data byte |
| wr_cpu | input | 3 | Number of the processor making the write |
| wr_nonsec | input | 1 | Write is non-secure |
| hw_irq | input | NUM_IRQ-32 | Hardware triggers for the shared interrupts |
| rd_addr | input | ADDR_W | Read address {region, index} |
| rd_cpu | input | 3 | Number of the processor making the read |
| rd_data | output | 8 | Read data byte (combinational) |
| cpu_pend_vec | output | NUM_CPU*NUM_IRQ | Pending view of every processor |
| cpu_pend | output | NUM_CPU | Any-pending summary for each processor |

## Verification
Two of this block's functions can fall in the same cycle: a hardware trigger and a clear-pending write. The bench drives hw_irq for one shared interrupt while a clear-pending write to that same interrupt is on the port, and expects the interrupt to stay pending. In the same write it also clears a neighbouring interrupt that has no trigger, and expects that one to drop. A target write does the same to a latched interrupt: it moves the pending state in the same edge, and the bench judges this by sweeping every processor's view through the read port and the output vectors after each write.

// File: rtl/pdist_pkg.sv
// Shared definitions for the pending distributor.
// Assumes a two-bit region field at the top of every register address.
package pdist_pkg;
    typedef enum logic [1:0] {
        RG_SET = 2'd0,
        RG_CLR = 2'd1,
        RG_GRP = 2'd2,
        RG_TGT = 2'd3
    } region_e;

    localparam int PRIV_IRQS = 32;
    localparam int CPU_W     = 3;
endpackage

// File: rtl/pdist_wr_decode.sv
// Turns one register write into set/clear strobes for each interrupt.
// Applies the security filter and holds the group bits.
// Assumes NUM_IRQ is a multiple of 8 and greater than 32.
module pdist_wr_decode
    import pdist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    parameter bit SEC_EN  = 1'b1,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int ADDR_W = IDX_W + 2,
    localparam int NSH    = NUM_IRQ - PRIV_IRQS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               wr_nonsec,
    output logic [NUM_IRQ-1:0] set_vec,
    output logic [NUM_IRQ-1:0] clr_vec,
    output logic [NSH-1:0]     tgt_we,
    output logic [7:0]         tgt_val,
    output logic [NUM_IRQ-1:0] grp_q
);
    localparam logic [7:0] ALL_MASK = 8'((1 << NUM_CPU) - 1);

    region_e          rg;
    logic [IDX_W-1:0] idx;

    assign rg      = region_e'(wr_addr[ADDR_W-1 -: 2]);
    assign idx     = wr_addr[IDX_W-1:0];
    assign tgt_val = wr_data & ALL_MASK;

    genvar k;
    for (k = 0; k < NUM_IRQ; k++) begin : g_irq
        logic byte_hit, allowed;
        assign byte_hit   = (idx == IDX_W'(k / 8));
        assign allowed    = !(SEC_EN && wr_nonsec && !grp_q[k]);
        assign set_vec[k] = wr_en && (rg == RG_SET) && byte_hit && wr_data[k % 8] && allowed;
        assign clr_vec[k] = wr_en && (rg == RG_CLR) && byte_hit && wr_data[k % 8] && allowed;
    end

    genvar j;
    for (j = 0; j < NSH; j++) begin : g_tgt
        if (NUM_CPU > 1) begin : g_multi
            assign tgt_we[j] = wr_en && (rg == RG_TGT) && (idx == IDX_W'(j + PRIV_IRQS));
        end else begin : g_single
            assign tgt_we[j] = 1'b0;
        end
    end

    // Group bits: one byte of them is rewritten by a group-region write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else begin
            for (int n = 0; n < NUM_IRQ; n++) begin
                if (wr_en && (rg == RG_GRP) && (idx == IDX_W'(n / 8)))
                    grp_q[n] <= wr_data[n % 8];
            end
        end
    end

    // R9: a non-secure write never produces a strobe for a group-0 interrupt
    assert_nonsec_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (SEC_EN && wr_nonsec) |-> (((set_vec | clr_vec) & ~grp_q) == '0));
endmodule

// File: rtl/pdist_priv_bank.sv
// Pending bits of the private interrupts, one bank of 32 for each processor.
// Only the bank of the writing processor is touched by a write.
// Assumes set and clear strobes never fall in the same cycle.
module pdist_priv_bank
    import pdist_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRIV_IRQS-1:0]  set_vec,
    input  logic [PRIV_IRQS-1:0]  clr_vec,
    input  logic [CPU_W-1:0]      wr_cpu,
    output logic [NUM_CPU-1:0][PRIV_IRQS-1:0] ppend
);
    // Bank update: only the bank of wr_cpu takes the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppend <= '0;
        end else begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (wr_cpu == CPU_W'(c))
                    ppend[c] <= (ppend[c] | set_vec) & ~clr_vec;
            end
        end
    end

    genvar c;
    for (c = 0; c < NUM_CPU; c++) begin : g_chk
        // R3: banks of other processors hold their value
        assert_bank_isolate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_cpu != CPU_W'(c)) |=> $stable(ppend[c]));
        // R3: a set strobe from this processor lands in its bank
        assert_priv_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ((wr_cpu == CPU_W'(c)) && (set_vec != '0)) |=> ((ppend[c] & $past(set_vec)) == $past(set_vec)));
        // R4: a clear strobe from this processor empties those bits
        assert_priv_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((wr_cpu == CPU_W'(c)) && (clr_vec != '0)) |=> ((ppend[c] & $past(clr_vec)) == '0));
    end
endmodule

// File: rtl/pdist_shared_array.sv
// Single pending latch and target mask for each shared interrupt.
// The view a processor gets is latch AND target bit, so a retarget moves pending state at once.
// Assumes target values arrive already masked to the processor count.
module pdist_shared_array
    import pdist_pkg::*;
#(
    parameter int NSH     = 32,
    parameter int NUM_CPU = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSH-1:0]      set_vec,
    input  logic [NSH-1:0]      clr_vec,
    input  logic [NSH-1:0]      hw_irq,
    input  logic [NSH-1:0]      tgt_we,
    input  logic [7:0]          tgt_val,
    output logic [NSH-1:0]      spend,
    output logic [NSH-1:0][7:0] tgt_q
);
    // Pending latch: the hardware trigger and a set win over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) spend <= '0;
        else        spend <= (spend & ~clr_vec) | set_vec | hw_irq;
    end

    // Target masks: one is rewritten per target write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else begin
            for (int j = 0; j < NSH; j++)
                if (tgt_we[j]) tgt_q[j] <= tgt_val;
        end
    end

    genvar j;
    for (j = 0; j < NSH; j++) begin : g_chk
        // R8: a hardware trigger always leaves the interrupt pending
        assert_hw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hw_irq[j] |=> spend[j]);
        // R5: a shared clear with no trigger empties the latch for all
        assert_shared_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[j] && !hw_irq[j]) |=> !spend[j]);
        // R7: a retarget keeps the latch, only the view moves
        assert_retarget_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_we[j] && !hw_irq[j]) |=> (spend[j] == $past(spend[j])));
        if (NUM_CPU < 8) begin : g_mask
            // R6: no stored target bit for a processor that does not exist
            assert_tgt_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (tgt_q[j] >> NUM_CPU) == 8'd0);
        end
    end
endmodule

// File: rtl/irq_pend_dist.sv
// Top of the pending distributor: ties decode, private banks and shared array together.
// Forms each processor's view and serves the combinational read port.
// Assumes 8 <= NUM_CPU*... : NUM_CPU in 1..8, NUM_IRQ a multiple of 8 above 32.
module irq_pend_dist
    import pdist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    parameter bit SEC_EN  = 1'b1,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int ADDR_W = IDX_W + 2,
    localparam int NSH    = NUM_IRQ - 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic [2:0]                 wr_cpu,
    input  logic                       wr_nonsec,
    input  logic [NSH-1:0]             hw_irq,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [2:0]                 rd_cpu,
    output logic [7:0]                 rd_data,
    output logic [NUM_CPU*NUM_IRQ-1:0] cpu_pend_vec,
    output logic [NUM_CPU-1:0]         cpu_pend
);
    localparam int         NBYTE    = NUM_IRQ / 8;
    localparam logic [7:0] ALL_MASK = (NUM_CPU > 1) ? 8'((1 << NUM_CPU) - 1) : 8'd0;

    logic [NUM_IRQ-1:0]        set_vec, clr_vec, grp_q;
    logic [NSH-1:0]            tgt_we, spend;
    logic [7:0]                tgt_val;
    logic [NSH-1:0][7:0]       tgt_q;
    logic [NUM_CPU-1:0][PRIV_IRQS-1:0] ppend;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0]   view;
    logic [NUM_IRQ-1:0][7:0]   tgt_full;

    pdist_wr_decode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .SEC_EN(SEC_EN)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_nonsec(wr_nonsec), .set_vec(set_vec), .clr_vec(clr_vec), .tgt_we(tgt_we),
        .tgt_val(tgt_val), .grp_q(grp_q)
    );

    pdist_priv_bank #(.NUM_CPU(NUM_CPU)) u_priv (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec[PRIV_IRQS-1:0]),
        .clr_vec(clr_vec[PRIV_IRQS-1:0]), .wr_cpu(wr_cpu), .ppend(ppend)
    );

    pdist_shared_array #(.NSH(NSH), .NUM_CPU(NUM_CPU)) u_shr (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec[NUM_IRQ-1:PRIV_IRQS]),
        .clr_vec(clr_vec[NUM_IRQ-1:PRIV_IRQS]), .hw_irq(hw_irq), .tgt_we(tgt_we),
        .tgt_val(tgt_val), .spend(spend), .tgt_q(tgt_q)
    );

    genvar c, k;
    for (k = 0; k < NUM_IRQ; k++) begin : g_irq
        if (k < PRIV_IRQS) begin : g_priv
            assign tgt_full[k] = ALL_MASK;
            for (c = 0; c < NUM_CPU; c++) begin : g_cpu
                assign view[c][k] = ppend[c][k];
            end
        end else begin : g_shr
            assign tgt_full[k] = (NUM_CPU > 1) ? tgt_q[k-PRIV_IRQS] : 8'd0;
            for (c = 0; c < NUM_CPU; c++) begin : g_cpu
                assign view[c][k] = spend[k-PRIV_IRQS] & tgt_q[k-PRIV_IRQS][c];
            end
        end
    end

    for (c = 0; c < NUM_CPU; c++) begin : g_sum
        assign cpu_pend[c] = |view[c];
    end
    assign cpu_pend_vec = view;

    region_e          rrg;
    logic [IDX_W-1:0] ridx;
    assign rrg  = region_e'(rd_addr[ADDR_W-1 -: 2]);
    assign ridx = rd_addr[IDX_W-1:0];

    // Read port: pick the byte of the requested region as seen by rd_cpu.
    always_comb begin
        rd_data = 8'd0;
        unique case (rrg)
            RG_SET, RG_CLR: begin
                for (int b = 0; b < NBYTE; b++)
                    for (int p = 0; p < NUM_CPU; p++)
                        if (ridx == IDX_W'(b) && rd_cpu == 3'(p))
                            rd_data = view[p][b*8 +: 8];
            end
            RG_GRP: begin
                for (int b = 0; b < NBYTE; b++)
                    if (ridx == IDX_W'(b)) rd_data = grp_q[b*8 +: 8];
            end
            RG_TGT: begin
                for (int n = 0; n < NUM_IRQ; n++)
                    if (ridx == IDX_W'(n)) rd_data = tgt_full[n];
            end
            default: rd_data = 8'd0;
        endcase
    end

    // R11: a processor with nothing pending shows a low summary
    assert_summary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((spend == '0) && (ppend == '0)) |-> (cpu_pend == '0));
endmodule

// File: tb/tb_irq_pend_dist.sv
module tb_irq_pend_dist;
    localparam int NI = 64;
    localparam int NC = 4;
    localparam int NS = NI - 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [2:0]    wr_cpu = '0;
    logic          wr_nonsec = 1'b0;
    logic [NS-1:0] hw_irq = '0;
    logic [7:0]    rd_addr = '0;
    logic [2:0]    rd_cpu = '0;
    logic [7:0]    rd_data;
    logic [NC*NI-1:0] cpu_pend_vec;
    logic [NC-1:0] cpu_pend;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // model state
    bit       mp [NC][32];
    bit       ms [NS];
    bit [7:0] mt [NS];
    bit       mg [NI];

    irq_pend_dist #(.NUM_IRQ(NI), .NUM_CPU(NC), .SEC_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_cpu(wr_cpu), .wr_nonsec(wr_nonsec), .hw_irq(hw_irq), .rd_addr(rd_addr),
        .rd_cpu(rd_cpu), .rd_data(rd_data), .cpu_pend_vec(cpu_pend_vec), .cpu_pend(cpu_pend)
    );

    always #5 clk = ~clk;

    function automatic bit ev(int c, int k);
        if (k < 32) return mp[c][k];
        return ms[k-32] & mt[k-32][c];
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One write; hw bits are applied in the same cycle and win over a clear (R8).
    task automatic wr(int rg, int idx, logic [7:0] d, int cpu, bit ns, logic [NS-1:0] hw = '0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {rg[1:0], idx[5:0]}; wr_data = d;
        wr_cpu = cpu[2:0]; wr_nonsec = ns; hw_irq = hw;
        @(negedge clk);
        wr_en = 1'b0; hw_irq = '0;
        if (rg <= 1 && idx < NI/8) begin
            for (int i = 0; i < 8; i++) begin
                int k = idx*8 + i;
                if (d[i] && !(ns && !mg[k])) begin
                    if (k < 32) begin
                        if (cpu < NC) mp[cpu][k] = (rg == 0);
                    end else ms[k-32] = (rg == 0);
                end
            end
        end else if (rg == 2 && idx < NI/8) begin
            for (int i = 0; i < 8; i++) mg[idx*8+i] = d[i];
        end else if (rg == 3 && idx >= 32 && idx < NI) begin
            mt[idx-32] = d & 8'h0F;
        end
        for (int j = 0; j < NS; j++) if (hw[j]) ms[j] = 1'b1;
    endtask

    // Sweep every readable byte and both output vectors against the model.
    task automatic check_all(string tag);
        for (int rg = 0; rg < 2; rg++)
            for (int c = 0; c < NC; c++)
                for (int b = 0; b < 10; b++) begin
                    logic [7:0] e = '0;
                    if (b < 8) for (int i = 0; i < 8; i++) e[i] = ev(c, b*8+i);
                    rd_addr = {rg[1:0], b[5:0]}; rd_cpu = c[2:0]; #1;
                    chk(tag, $sformatf("pend rg%0d cpu%0d byte%0d", rg, c, b), 64'(rd_data), 64'(e));
                end
        for (int k = 0; k < NI; k++) begin
            logic [7:0] e = (k < 32) ? 8'h0F : mt[k-32];
            rd_addr = {2'd3, k[5:0]}; #1;
            chk(tag, $sformatf("target %0d", k), 64'(rd_data), 64'(e));
        end
        for (int b = 0; b < 10; b++) begin
            logic [7:0] e = '0;
            if (b < 8) for (int i = 0; i < 8; i++) e[i] = mg[b*8+i];
            rd_addr = {2'd2, b[5:0]}; #1;
            chk(tag, $sformatf("group byte%0d", b), 64'(rd_data), 64'(e));
        end
        for (int c = 0; c < NC; c++) begin
            logic [NI-1:0] e;
            for (int k = 0; k < NI; k++) e[k] = ev(c, k);
            chk(tag, $sformatf("vec cpu%0d", c), 64'(cpu_pend_vec[c*NI +: NI]), 64'(e));
            chk(tag, $sformatf("any cpu%0d", c), 64'(cpu_pend[c]), 64'(|e));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R9: non-secure writes against group-0 interrupts
        wr(0, 0, 8'hFF, 0, 1'b1);           check_all("R9");
        wr(2, 0, 8'h0F, 0, 1'b0);           check_all("R9");
        wr(0, 0, 8'hFF, 0, 1'b1);           check_all("R9");
        wr(1, 0, 8'hFF, 0, 1'b1);           check_all("R9");
        wr(2, 5, 8'hF0, 0, 1'b0);
        wr(0, 5, 8'hFF, 1, 1'b1);           check_all("R9");
        wr(1, 5, 8'hFF, 1, 1'b0);           check_all("R9");

        // R3: private set per processor, then an absent processor number
        for (int c = 0; c < NC; c++) begin
            for (int b = 0; b < 4; b++) wr(0, b, 8'(c*37 + b*11 + 1), c, 1'b0);
            check_all("R3");
        end
        wr(0, 1, 8'hFF, 5, 1'b0);           check_all("R3");

        // R4: private clear only in the writer's bank
        for (int c = 0; c < NC; c++) begin
            wr(1, c, 8'hA5, c, 1'b0);
            check_all("R4");
        end

        // R6: target masks, high bits dropped; private targets fixed
        for (int k = 32; k < NI; k++) wr(3, k, 8'((k*5) | ((k & 1) << 7)), 0, 1'b0);
        wr(3, 32, 8'hFF, 1, 1'b0);
        wr(3, 3, 8'h01, 2, 1'b0);           check_all("R6");

        // R5: shared set follows the mask, shared clear drops it for all
        for (int b = 4; b < 8; b++) wr(0, b, 8'hFF, b - 4, 1'b0);
        check_all("R5");
        wr(1, 6, 8'h3C, 2, 1'b0);           check_all("R5");

        // R2: zero data bits change nothing
        wr(0, 7, 8'h00, 0, 1'b0);
        wr(1, 4, 8'h00, 3, 1'b0);           check_all("R2");

        // R7: retarget of pending interrupts, and an empty-mask latch
        wr(3, 33, 8'h0C, 0, 1'b0);
        wr(3, 40, 8'h00, 0, 1'b0);          check_all("R7");
        wr(0, 5, 8'h01, 0, 1'b0);           check_all("R7");
        wr(3, 40, 8'h02, 3, 1'b0);          check_all("R7");
        wr(3, 63, 8'h01, 1, 1'b0);          check_all("R7");

        // R8: hardware trigger alone, then colliding with a clear
        wr(1, 6, 8'hFF, 0, 1'b0);           check_all("R8");
        wr(2, 1, 8'h00, 0, 1'b0, 32'h0004_0000);  check_all("R8");
        wr(1, 6, 8'h06, 1, 1'b0, 32'h0002_0000);  check_all("R8");
        wr(0, 2, 8'h00, 0, 1'b0, 32'hFFFF_FFFF);  check_all("R8");

        // R10: indices beyond the configured count
        wr(0, 8,  8'hFF, 0, 1'b0);
        wr(0, 63, 8'hFF, 1, 1'b0);
        wr(1, 9,  8'hFF, 2, 1'b0);
        wr(2, 12, 8'hFF, 0, 1'b0);          check_all("R10");

        // R11: final sweep of views and summaries after clearing one processor
        for (int b = 0; b < 4; b++) wr(1, b, 8'hFF, 3, 1'b0);
        for (int b = 4; b < 8; b++) wr(1, b, 8'hFF, 3, 1'b0);
        check_all("R11");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule